// File: doc/BRIEF.md
# Split-Mode Dual 8-Bit Timer

This block holds a pair of timer/counters in the configuration where the first timer is broken into two independent 8-bit counters. A free-running prescaler divides the clock by twelve to produce one machine-cycle tick. The low counter keeps the first timer's full control set: run bit, timer/counter select, gate bit, gate pin and overflow flag. The high counter only ever counts machine cycles. It borrows the second timer's run bit and overflow flag, so its wrap raises the second timer's interrupt request.

While split mode is active, the second timer's own 8-bit counter is held still, as though its run bit were cleared. With split mode off, that counter runs from the second timer's run bit and drives the second flag, and the high counter holds.

A small write port loads any of the three counters and clears the flags. A write to a counter takes precedence over an increment in the same cycle.

Top module: `splitTimerPair`

## Requirements
- R1: While reset is asserted, all three counters read 0 and both flags read 0.
- R2: The machine-cycle tick falls on the 12th clock after reset is released and then on every 12th clock. In split mode with runB=1, hiCnt increments by one on each tick.
- R3: hiCnt never counts the count pin, whatever ctSelA and cntPin do. It advances exactly ten times in any 120 clocks of split mode with runB=1.
- R4: With ctSelA=0, loCnt increments on each tick when runA=1 and either gateA=0 or intPin=1. Otherwise it holds.
- R5: With ctSelA=1 and the same enable as R4, loCnt increments once for each 1-to-0 change of cntPin between successive tick samples. The pin is sampled at ticks, and its sampled value resets to 0.
- R6: Each counter wraps from 0xFF to 0x00. A loCnt wrap sets ovfA. In split mode, an hiCnt wrap sets ovfB.
- R7: In split mode, auxCnt does not change except through a write, whatever the value of runB.
- R8: With splitMode=0, auxCnt increments on each tick when runB=1, its wrap sets ovfB, and hiCnt holds.
- R9: A flag stays set until a write to address 3 with data bit 0 set (clears ovfA) or data bit 1 set (clears ovfB). A clear wins over a same-cycle set.
- R10: A write with wrAddr 0, 1 or 2 loads loCnt, hiCnt or auxCnt from wrData at that clock edge. It replaces any increment due in that cycle, so that increment causes no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntPin | input | 1 | External event pin for the low counter |
| intPin | input | 1 | External gate pin for the low counter |
| splitMode | input | 1 | Selects the split configuration |
| runA | input | 1 | First timer run bit (drives the low counter) |
| ctSelA | input | 1 | Low counter source: 0 machine cycles, 1 pin edges |
| gateA | input | 1 | Low counter gate enable |
| runB | input | 1 | Second timer run bit |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 2 | 0 low, 1 high, 2 second timer, 3 flag clear |
| wrData | input | 8 | Write data |
| loCnt | output | 8 | Low counter value |
| hiCnt | output | 8 | High counter value |
| auxCnt | output | 8 | Second timer counter value |
| ovfA | output | 1 | First timer overflow flag |
| ovfB | output | 1 | Second timer overflow flag |

## Verification
The assertions assume that every input is synchronous to clk and changes only away from its rising edge. They also assume that a write lasts exactly one clock, so that a loaded counter is compared with the data of the same cycle. The bench drives all inputs on the falling edge and gives each write a single-cycle strobe. Its random phase toggles mode, run and gate bits rarely and the pins often, so pin edges and writes land on every phase of the prescaler, including cycles that carry a tick.

// File: rtl/splitTmrPkg.sv
package splitTmrPkg;
  typedef struct packed {
    logic incLo;
    logic incHi;
    logic incAux;
  } tmrStrobe_t;

  typedef enum logic [1:0] {
    ADDR_LO   = 2'd0,
    ADDR_HI   = 2'd1,
    ADDR_AUX  = 2'd2,
    ADDR_FLAG = 2'd3
  } tmrAddr_e;
endpackage

// File: rtl/splitTmrCtrl.sv
module splitTmrCtrl
  import splitTmrPkg::*;
#(
  parameter int PRESCALE = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cntPin,
  input  logic       intPin,
  input  logic       splitMode,
  input  logic       runA,
  input  logic       ctSelA,
  input  logic       gateA,
  input  logic       runB,
  output tmrStrobe_t strobe
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PW-1:0] psc;
  logic          tick;
  logic          cntSamp;
  logic          cntFall;
  logic          loEnable;

  assign tick = (psc == PW'(PRESCALE - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psc     <= '0;
      cntSamp <= 1'b0;
    end else begin
      psc <= tick ? '0 : psc + 1'b1;
      if (tick) cntSamp <= cntPin;
    end
  end

  assign cntFall = tick && cntSamp && !cntPin;

  always_comb begin
    loEnable      = runA && (!gateA || intPin);
    strobe.incLo  = loEnable && (ctSelA ? cntFall : tick);
    strobe.incHi  = tick && splitMode && runB;
    strobe.incAux = tick && !splitMode && runB;
  end
endmodule

// File: rtl/splitTmrData.sv
module splitTmrData
  import splitTmrPkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  tmrStrobe_t   strobe,
  input  logic         wrEn,
  input  logic [1:0]   wrAddr,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] loCnt,
  output logic [W-1:0] hiCnt,
  output logic [W-1:0] auxCnt,
  output logic         ovfA,
  output logic         ovfB
);
  localparam int NCNT = 3;

  logic [NCNT-1:0]        incVec;
  logic [NCNT-1:0]        wrapVec;
  logic [NCNT-1:0][W-1:0] cntAll;
  logic                   clrA;
  logic                   clrB;

  assign incVec = {strobe.incAux, strobe.incHi, strobe.incLo};

  for (genvar i = 0; i < NCNT; i++) begin : gCnt
    logic         wrThis;
    logic [W-1:0] val;
    assign wrThis = wrEn && (wrAddr == 2'(i));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          val <= '0;
      else if (wrThis)    val <= wrData;
      else if (incVec[i]) val <= val + 1'b1;
    end
    assign wrapVec[i] = incVec[i] && !wrThis && (val == '1);
    assign cntAll[i]  = val;
  end

  assign loCnt  = cntAll[0];
  assign hiCnt  = cntAll[1];
  assign auxCnt = cntAll[2];

  assign clrA = wrEn && (wrAddr == ADDR_FLAG) && wrData[0];
  assign clrB = wrEn && (wrAddr == ADDR_FLAG) && wrData[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfA <= 1'b0;
      ovfB <= 1'b0;
    end else begin
      if (clrA)            ovfA <= 1'b0;
      else if (wrapVec[0]) ovfA <= 1'b1;
      if (clrB)                          ovfB <= 1'b0;
      else if (wrapVec[1] || wrapVec[2]) ovfB <= 1'b1;
    end
  end
endmodule

// File: rtl/splitTimerPair.sv
module splitTimerPair
  import splitTmrPkg::*;
#(
  parameter int W        = 8,
  parameter int PRESCALE = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cntPin,
  input  logic         intPin,
  input  logic         splitMode,
  input  logic         runA,
  input  logic         ctSelA,
  input  logic         gateA,
  input  logic         runB,
  input  logic         wrEn,
  input  logic [1:0]   wrAddr,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] loCnt,
  output logic [W-1:0] hiCnt,
  output logic [W-1:0] auxCnt,
  output logic         ovfA,
  output logic         ovfB
);
  tmrStrobe_t strobe;

  splitTmrCtrl #(.PRESCALE(PRESCALE)) uCtrl (
    .clk(clk), .rstN(rstN), .cntPin(cntPin), .intPin(intPin),
    .splitMode(splitMode), .runA(runA), .ctSelA(ctSelA), .gateA(gateA),
    .runB(runB), .strobe(strobe)
  );

  splitTmrData #(.W(W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .loCnt(loCnt), .hiCnt(hiCnt), .auxCnt(auxCnt),
    .ovfA(ovfA), .ovfB(ovfB)
  );
endmodule

// File: rtl/splitTmrChk.sv
module splitTmrChk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         intPin,
  input logic         splitMode,
  input logic         runA,
  input logic         gateA,
  input logic         runB,
  input logic         wrEn,
  input logic [1:0]   wrAddr,
  input logic [W-1:0] wrData,
  input logic [W-1:0] loCnt,
  input logic [W-1:0] hiCnt,
  input logic [W-1:0] auxCnt,
  input logic         ovfA,
  input logic         ovfB
);
  AST_AUX_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (splitMode && !(wrEn && wrAddr == 2'd2)) |=> (auxCnt == $past(auxCnt))); // R7

  AST_HI_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrAddr == 2'd1) |=> ((hiCnt == $past(hiCnt)) ||
      ((hiCnt == W'($past(hiCnt) + 1'b1)) && $past(splitMode && runB)))); // R2

  AST_LO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ((!runA || (gateA && !intPin)) && !(wrEn && wrAddr == 2'd0)) |=> (loCnt == $past(loCnt))); // R4

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ovfA && !(wrEn && wrAddr == 2'd3 && wrData[0])) |=> ovfA); // R9

  AST_OVFB_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    (!ovfB && splitMode && (hiCnt != '1)) |=> !ovfB); // R6

  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd0) |=> (loCnt == $past(wrData))); // R10
endmodule

bind splitTimerPair splitTmrChk #(.W(W)) uChk (
  .clk(clk), .rstN(rstN), .intPin(intPin), .splitMode(splitMode),
  .runA(runA), .gateA(gateA), .runB(runB), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .loCnt(loCnt), .hiCnt(hiCnt), .auxCnt(auxCnt),
  .ovfA(ovfA), .ovfB(ovfB)
);

// File: tb/tb_splitTimerPair.sv
module tb_splitTimerPair;
  logic       clk = 1'b0;
  logic       rstN;
  logic       cntPin, intPin, splitMode, runA, ctSelA, gateA, runB, wrEn;
  logic [1:0] wrAddr;
  logic [7:0] wrData;
  logic [7:0] loCnt, hiCnt, auxCnt;
  logic       ovfA, ovfB;

  int nChecks = 0;
  int nFail   = 0;

  always #10 clk = ~clk;

  splitTimerPair dut (
    .clk(clk), .rstN(rstN), .cntPin(cntPin), .intPin(intPin),
    .splitMode(splitMode), .runA(runA), .ctSelA(ctSelA), .gateA(gateA),
    .runB(runB), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .loCnt(loCnt), .hiCnt(hiCnt), .auxCnt(auxCnt), .ovfA(ovfA), .ovfB(ovfB)
  );

  // Reference model built from the requirements
  int         mPsc;
  logic       mSamp, mA, mB;
  logic [7:0] mLo, mHi, mAux;

  function automatic logic [7:0] nextCnt(logic [7:0] cur, logic wr, logic inc, logic [7:0] d);
    if (wr) return d;
    if (inc) return cur + 8'd1;
    return cur;
  endfunction

  function automatic logic wraps(logic [7:0] cur, logic wr, logic inc);
    return inc && !wr && (cur == 8'hFF);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPsc <= 0; mSamp <= 1'b0; mA <= 1'b0; mB <= 1'b0;
      mLo <= 8'd0; mHi <= 8'd0; mAux <= 8'd0;
    end else begin
      automatic logic tk   = (mPsc == 11);
      automatic logic fl   = tk && mSamp && !cntPin;
      automatic logic iLo  = runA && (!gateA || intPin) && (ctSelA ? fl : tk);
      automatic logic iHi  = tk && splitMode && runB;
      automatic logic iAux = tk && !splitMode && runB;
      automatic logic wLo  = wrEn && wrAddr == 2'd0;
      automatic logic wHi  = wrEn && wrAddr == 2'd1;
      automatic logic wAux = wrEn && wrAddr == 2'd2;
      automatic logic cA   = wrEn && wrAddr == 2'd3 && wrData[0];
      automatic logic cB   = wrEn && wrAddr == 2'd3 && wrData[1];
      mPsc <= tk ? 0 : mPsc + 1;
      if (tk) mSamp <= cntPin;
      mLo  <= nextCnt(mLo, wLo, iLo, wrData);
      mHi  <= nextCnt(mHi, wHi, iHi, wrData);
      mAux <= nextCnt(mAux, wAux, iAux, wrData);
      if (cA) mA <= 1'b0; else if (wraps(mLo, wLo, iLo)) mA <= 1'b1;
      if (cB) mB <= 1'b0;
      else if (wraps(mHi, wHi, iHi) || wraps(mAux, wAux, iAux)) mB <= 1'b1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [7:0] d);
    wrAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic finishUp();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishUp();
  end

  initial begin
    logic [7:0] h0, a0, l0;
    void'($urandom(32'h5EED_1234));
    rstN = 1'b0; cntPin = 0; intPin = 0; splitMode = 0; runA = 0; ctSelA = 0;
    gateA = 0; runB = 0; wrEn = 0; wrAddr = 0; wrData = 0;
    cyc(3);
    check("R1 loCnt", loCnt, 0); check("R1 hiCnt", hiCnt, 0);
    check("R1 auxCnt", auxCnt, 0); check("R1 ovfA", ovfA, 0); check("R1 ovfB", ovfB, 0);
    rstN = 1'b1;

    // R2 and R7: split mode, high half counts, second timer frozen
    splitMode = 1; runB = 1;
    cyc(2); h0 = hiCnt; a0 = auxCnt;
    cyc(120);
    check("R2 hi delta", 8'(hiCnt - h0), 10);
    check("R7 aux frozen", auxCnt, a0);

    // R3: count pin activity does not reach the high half
    ctSelA = 1; h0 = hiCnt;
    for (int k = 0; k < 24; k++) begin cntPin = ~cntPin; cyc(5); end
    check("R3 hi delta", 8'(hiCnt - h0), 10);
    ctSelA = 0;

    // R8: non-split, second timer runs, high half holds
    splitMode = 0; h0 = hiCnt; a0 = auxCnt;
    cyc(120);
    check("R8 aux delta", 8'(auxCnt - a0), 10);
    check("R8 hi hold", hiCnt, h0);

    // R7 with run bit clear as well
    splitMode = 1; runB = 0; a0 = auxCnt;
    cyc(60);
    check("R7 aux frozen runB0", auxCnt, a0);

    // R4: gating of the low half in timer mode
    runA = 1; gateA = 1; intPin = 0; l0 = loCnt;
    cyc(120);
    check("R4 gated off", 8'(loCnt - l0), 0);
    intPin = 1; l0 = loCnt;
    cyc(120);
    check("R4 gate pin high", 8'(loCnt - l0), 10);
    gateA = 0; intPin = 0; l0 = loCnt;
    cyc(120);
    check("R4 gate off", 8'(loCnt - l0), 10);

    // R5: counter mode on falling edges
    ctSelA = 1; cntPin = 1;
    cyc(24); l0 = loCnt;
    for (int k = 0; k < 3; k++) begin
      cntPin = 0; cyc(24); cntPin = 1; cyc(24);
    end
    check("R5 edges", 8'(loCnt - l0), 3);
    runA = 0; ctSelA = 0;

    // R10: writes load counters, also against a running counter
    doWrite(2'd0, 8'h55);
    check("R10 lo load", loCnt, 8'h55);
    runB = 1;
    doWrite(2'd1, 8'hFE);
    check("R10 hi load", hiCnt, 8'hFE);

    // R6: wraps set the flags
    cyc(30);
    check("R6 ovfB set", ovfB, 1);
    check("R6 hi wrapped", (hiCnt < 8'd3) ? 1 : 0, 1);
    runB = 0;
    doWrite(2'd0, 8'hFF);
    runA = 1;
    cyc(15);
    check("R6 ovfA set", ovfA, 1);
    runA = 0;

    // R9: flags sticky, then cleared individually
    cyc(50);
    check("R9 ovfA sticky", ovfA, 1); check("R9 ovfB sticky", ovfB, 1);
    doWrite(2'd3, 8'h01);
    check("R9 ovfA clear", ovfA, 0); check("R9 ovfB kept", ovfB, 1);
    doWrite(2'd3, 8'h02);
    check("R9 ovfB clear", ovfB, 0);

    // Random phase against the reference model
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      check("R4 loCnt model", loCnt, mLo);
      check("R2 hiCnt model", hiCnt, mHi);
      check("R8 auxCnt model", auxCnt, mAux);
      check("R6 ovfA model", ovfA, mA);
      check("R6 ovfB model", ovfB, mB);
      wrEn = 1'b0;
      if ($urandom_range(499) == 0) splitMode = ~splitMode;
      if ($urandom_range(199) == 0) runA = ~runA;
      if ($urandom_range(199) == 0) runB = ~runB;
      if ($urandom_range(199) == 0) gateA = ~gateA;
      if ($urandom_range(199) == 0) ctSelA = ~ctSelA;
      if ($urandom_range(29) == 0) intPin = ~intPin;
      if ($urandom_range(19) == 0) cntPin = ~cntPin;
      if ($urandom_range(39) == 0) begin
        wrEn = 1'b1;
        wrAddr = 2'($urandom_range(3));
        wrData = ($urandom_range(3) == 0) ? 8'hFF : 8'($urandom_range(255));
      end
    end
    wrEn = 1'b0;
    @(negedge clk);
    finishUp();
  end
endmodule